// File: doc/BRIEF.md
# Fetch-Stage Branch Predictor with Tagged Targets and Tagless Direction Counters

This block predicts the next fetch address. Every cycle the fetch stage presents its program counter. The block answers combinationally with three values: whether the address is a known branch, which way the branch is expected to go, and the next address to fetch. Branch identity and target come from a small direct-mapped target table. Each entry of that table keeps the complete branch address as a tag, so a target is only used on an exact match. Direction comes from a separate table of 2-bit saturating counters. That table has no tag, so different branches whose index bits coincide share one counter.

When a branch resolves later in the pipeline, the back end reports its address, its actual direction and its actual destination. The block then trains the counter and, for taken branches, writes the target entry. If that entry belongs to a different branch, it is taken over.

Top module: `branch_predictor`

## Requirements
- R1: After reset, every target entry is invalid and every counter holds 01 (weakly not taken), so any lookup returns hit=0, taken=0, next = PC+4.
- R2: The target table is indexed by PC bits [5:2] (16 entries). A lookup hits only when the entry is valid and its stored full PC equals the fetch PC; a same-index entry with a different PC gives hit=0.
- R3: The direction table is indexed by PC bits [7:2] (64 counters) with no tag check, so two PCs that agree in bits [7:2] read and train the same counter.
- R4: A counter counts up on a taken resolve and down on a not-taken resolve, saturating at 11 and 00; the predicted direction is the counter's upper bit (10 and 11 mean taken).
- R5: From 11, one not-taken resolve still predicts taken; a second one flips the prediction to not taken.
- R6: The next PC is the stored target when the lookup hits and the direction is taken; otherwise it is PC+4.
- R7: A taken resolve that misses in the target table writes that index with the resolved PC and target, replacing the previous occupant.
- R8: A taken resolve that hits rewrites the stored target; a not-taken resolve that hits leaves the entry and its target unchanged.
- R9: A not-taken resolve that misses allocates no target entry and disturbs none, but still moves its direction counter.
- R10: A lookup in the same cycle as a resolve to the same index returns the contents from before that resolve; the new contents appear from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_hit | output | 1 | Fetch PC matches a valid target entry |
| pred_taken | output | 1 | Direction from the counter selected by the fetch PC |
| pred_next_pc | output | 32 | Predicted next fetch address |
| rsv_valid | input | 1 | A branch resolution is presented this cycle |
| rsv_pc | input | 32 | Address of the resolved branch |
| rsv_taken | input | 1 | Actual direction of the resolved branch |
| rsv_target | input | 32 | Actual destination of the resolved branch |

## Verification
A lookup and a resolve can land on the same table index in one cycle. The bench provokes this by driving a fetch PC and a resolution of that same PC on one falling edge. The resolution flips the counter and installs a new target. The scoreboard expects the lookup sampled before the next rising edge to show the old direction and old next PC, and a lookup one cycle later to show the new target. Aliasing is covered separately: a PC that shares a counter but not a target entry must report the shared direction while still missing.

// File: rtl/bp_pkg.sv
package bp_pkg;

    localparam int unsigned PC_W       = 32;
    localparam int unsigned INSN_SHIFT = 2;

    typedef logic [PC_W-1:0] pc_t;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_e;

    typedef struct packed {
        logic valid;
        pc_t  tag;
        pc_t  target;
    } tgt_entry_t;

    typedef struct packed {
        logic valid;
        pc_t  pc;
        logic taken;
        pc_t  target;
    } resolve_t;

    typedef struct packed {
        logic hit;
        logic taken;
        pc_t  next_pc;
    } pred_t;

    function automatic ctr_e ctr_step(ctr_e c, logic taken);
        ctr_e n;
        n = c;
        if (taken) begin
            case (c)
                CTR_SNT: n = CTR_WNT;
                CTR_WNT: n = CTR_WT;
                CTR_WT:  n = CTR_ST;
                default: n = CTR_ST;
            endcase
        end else begin
            case (c)
                CTR_ST:  n = CTR_WT;
                CTR_WT:  n = CTR_WNT;
                CTR_WNT: n = CTR_SNT;
                default: n = CTR_SNT;
            endcase
        end
        return n;
    endfunction

    function automatic logic ctr_says_taken(ctr_e c);
        return c[1];
    endfunction

    function automatic pc_t seq_pc(pc_t pc);
        return pc + pc_t'(4);
    endfunction

endpackage

// File: rtl/bp_target_table.sv
module bp_target_table
    import bp_pkg::*;
#(
    parameter int unsigned ENTRIES = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  pc_t      rd_pc,
    output logic     rd_hit,
    output pc_t      rd_target,
    input  resolve_t upd
);
    localparam int unsigned IDX_W = $clog2(ENTRIES);

    tgt_entry_t       ent_q [ENTRIES];
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;
    logic             wr_en;
    logic [ENTRIES-1:0] valid_vec;

    assign rd_idx = rd_pc[INSN_SHIFT +: IDX_W];
    assign wr_idx = upd.pc[INSN_SHIFT +: IDX_W];
    // Taken resolves both allocate on a miss and refresh on a hit.
    assign wr_en  = upd.valid && upd.taken;

    always_comb begin
        tgt_entry_t e;
        e         = ent_q[rd_idx];
        rd_hit    = e.valid && (e.tag == rd_pc);
        rd_target = e.target;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(ENTRIES); i++) begin
                ent_q[i] <= '0;
            end
        end else if (wr_en) begin
            ent_q[wr_idx] <= '{valid: 1'b1, tag: upd.pc, target: upd.target};
        end
    end

    genvar g;
    generate
        for (g = 0; g < int'(ENTRIES); g++) begin : g_valid
            assign valid_vec[g] = ent_q[g].valid;
        end
    endgenerate

    // R1
    tgt_reset_clear_chk: assert property (@(posedge clk)
        rst |=> (valid_vec == '0));

    // R7
    tgt_alloc_chk: assert property (@(posedge clk) disable iff (rst)
        (upd.valid && upd.taken) |=>
            (ent_q[$past(wr_idx)].valid && ent_q[$past(wr_idx)].tag == $past(upd.pc)
             && ent_q[$past(wr_idx)].target == $past(upd.target)));

    // R9
    tgt_no_alloc_chk: assert property (@(posedge clk) disable iff (rst)
        (upd.valid && !upd.taken) |=> $stable(valid_vec));

endmodule

// File: rtl/bp_dir_table.sv
module bp_dir_table
    import bp_pkg::*;
#(
    parameter int unsigned ENTRIES = 64
) (
    input  logic     clk,
    input  logic     rst,
    input  pc_t      rd_pc,
    output logic     rd_taken,
    input  resolve_t upd
);
    localparam int unsigned IDX_W = $clog2(ENTRIES);

    ctr_e             ctr_q [ENTRIES];
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;
    logic [ENTRIES-1:0] is_wnt;

    assign rd_idx   = rd_pc[INSN_SHIFT +: IDX_W];
    assign wr_idx   = upd.pc[INSN_SHIFT +: IDX_W];
    assign rd_taken = ctr_says_taken(ctr_q[rd_idx]);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(ENTRIES); i++) begin
                ctr_q[i] <= CTR_WNT;
            end
        end else if (upd.valid) begin
            ctr_q[wr_idx] <= ctr_step(ctr_q[wr_idx], upd.taken);
        end
    end

    genvar g;
    generate
        for (g = 0; g < int'(ENTRIES); g++) begin : g_wnt
            assign is_wnt[g] = (ctr_q[g] == CTR_WNT);
        end
    endgenerate

    // R1
    dir_reset_wnt_chk: assert property (@(posedge clk)
        rst |=> (&is_wnt));

    // R4
    dir_sat_high_chk: assert property (@(posedge clk) disable iff (rst)
        (upd.valid && upd.taken && ctr_q[wr_idx] == CTR_ST) |=>
            (ctr_q[$past(wr_idx)] == CTR_ST));

    // R4
    dir_sat_low_chk: assert property (@(posedge clk) disable iff (rst)
        (upd.valid && !upd.taken && ctr_q[wr_idx] == CTR_SNT) |=>
            (ctr_q[$past(wr_idx)] == CTR_SNT));

    // R5
    dir_hysteresis_chk: assert property (@(posedge clk) disable iff (rst)
        (upd.valid && !upd.taken && ctr_q[wr_idx] == CTR_ST) |=>
            (ctr_q[$past(wr_idx)] == CTR_WT));

endmodule

// File: rtl/bp_next_sel.sv
module bp_next_sel
    import bp_pkg::*;
(
    input  pc_t   pc,
    input  logic  hit,
    input  logic  taken,
    input  pc_t   target,
    output pred_t pred
);
    always_comb begin
        pred.hit     = hit;
        pred.taken   = taken;
        pred.next_pc = (hit && taken) ? target : seq_pc(pc);
    end
endmodule

// File: rtl/branch_predictor.sv
module branch_predictor
    import bp_pkg::*;
#(
    parameter int unsigned TGT_ENTRIES = 16,
    parameter int unsigned DIR_ENTRIES = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] fetch_pc,
    output logic        pred_hit,
    output logic        pred_taken,
    output logic [31:0] pred_next_pc,
    input  logic        rsv_valid,
    input  logic [31:0] rsv_pc,
    input  logic        rsv_taken,
    input  logic [31:0] rsv_target
);
    resolve_t upd;
    logic     t_hit;
    pc_t      t_target;
    logic     d_taken;
    pred_t    pred;

    assign upd = '{valid: rsv_valid, pc: rsv_pc, taken: rsv_taken, target: rsv_target};

    bp_target_table #(.ENTRIES(TGT_ENTRIES)) u_tgt (
        .clk       (clk),
        .rst       (rst),
        .rd_pc     (fetch_pc),
        .rd_hit    (t_hit),
        .rd_target (t_target),
        .upd       (upd)
    );

    bp_dir_table #(.ENTRIES(DIR_ENTRIES)) u_dir (
        .clk      (clk),
        .rst      (rst),
        .rd_pc    (fetch_pc),
        .rd_taken (d_taken),
        .upd      (upd)
    );

    bp_next_sel u_sel (
        .pc     (fetch_pc),
        .hit    (t_hit),
        .taken  (d_taken),
        .target (t_target),
        .pred   (pred)
    );

    assign pred_hit     = pred.hit;
    assign pred_taken   = pred.taken;
    assign pred_next_pc = pred.next_pc;

    // R6
    seq_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
        !pred_hit |-> (pred_next_pc == fetch_pc + 32'd4));

    // R6
    seq_on_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
        !pred_taken |-> (pred_next_pc == fetch_pc + 32'd4));

endmodule

// File: tb/branch_predictor_bench.sv
module branch_predictor_bench;

    typedef struct {
        logic        hit;
        logic        taken;
        logic [31:0] next_pc;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_pc = '0;
    logic        pred_hit;
    logic        pred_taken;
    logic [31:0] pred_next_pc;
    logic        rsv_valid = 1'b0;
    logic [31:0] rsv_pc = '0;
    logic        rsv_taken = 1'b0;
    logic [31:0] rsv_target = '0;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    exp_t sb_q[$];
    event smp_ev;

    always #4 clk = ~clk;

    branch_predictor u_branch_predictor (
        .clk          (clk),
        .rst          (rst),
        .fetch_pc     (fetch_pc),
        .pred_hit     (pred_hit),
        .pred_taken   (pred_taken),
        .pred_next_pc (pred_next_pc),
        .rsv_valid    (rsv_valid),
        .rsv_pc       (rsv_pc),
        .rsv_taken    (rsv_taken),
        .rsv_target   (rsv_target)
    );

    // monitor: pops one expectation per sample event
    initial begin
        forever begin
            @(smp_ev);
            #1;
            if (sb_q.size() != 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_cmp++;
                if (pred_hit !== e.hit || pred_taken !== e.taken || pred_next_pc !== e.next_pc) begin
                    n_bad++;
                    $display("FAIL %s pc=%h: got hit=%b taken=%b next=%h expected hit=%b taken=%b next=%h",
                             e.req, fetch_pc, pred_hit, pred_taken, pred_next_pc,
                             e.hit, e.taken, e.next_pc);
                end
            end
        end
    end

    task automatic push_exp(logic h, logic t, logic [31:0] n, string req);
        exp_t e;
        e.hit = h; e.taken = t; e.next_pc = n; e.req = req;
        sb_q.push_back(e);
        -> smp_ev;
        #2;
    endtask

    task automatic look(logic [31:0] pc, logic h, logic t, logic [31:0] n, string req);
        @(negedge clk);
        fetch_pc = pc;
        push_exp(h, t, n, req);
    endtask

    task automatic resolve(logic [31:0] pc, logic tk, logic [31:0] tgt);
        @(negedge clk);
        rsv_valid = 1'b1; rsv_pc = pc; rsv_taken = tk; rsv_target = tgt;
        @(posedge clk);
        #1 rsv_valid = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        look(32'h100, 0, 0, 32'h104, "R1");
        look(32'h3C0, 0, 0, 32'h3C4, "R1");

        // R7 allocate, counter 01->10
        resolve(32'h100, 1, 32'h800);
        look(32'h100, 1, 1, 32'h800, "R7/R6");
        // R2: same target index, different tag; own counter idx16 still 01
        look(32'h140, 0, 0, 32'h144, "R2");
        // R3: shares counter idx0 with 0x100 (taken) but misses target
        look(32'h200, 0, 1, 32'h204, "R3");

        // R5: 10->11, then NT ->10 still taken, NT ->01 not taken
        resolve(32'h100, 1, 32'h800);
        resolve(32'h100, 0, 32'hDEAD0);
        look(32'h100, 1, 1, 32'h800, "R5/R8");
        resolve(32'h100, 0, 32'hDEAD0);
        look(32'h100, 1, 0, 32'h104, "R5/R6");

        // R4 upper saturation: 01->10->11->11, NT ->10
        resolve(32'h100, 1, 32'h800);
        resolve(32'h100, 1, 32'h800);
        resolve(32'h100, 1, 32'h800);
        resolve(32'h100, 0, 32'h800);
        look(32'h100, 1, 1, 32'h800, "R4");
        // R4 lower saturation: 10->01->00->00, T ->01
        resolve(32'h100, 0, 32'h800);
        resolve(32'h100, 0, 32'h800);
        resolve(32'h100, 0, 32'h800);
        resolve(32'h100, 1, 32'h800);
        look(32'h100, 1, 0, 32'h104, "R4");
        resolve(32'h100, 1, 32'h800);
        look(32'h100, 1, 1, 32'h800, "R4");

        // R8: taken hit rewrites target (counter 10->11)
        resolve(32'h100, 1, 32'h900);
        look(32'h100, 1, 1, 32'h900, "R8");

        // R9: not-taken miss at idx0 leaves entry, counter idx48 01->00
        resolve(32'h3C0, 0, 32'h1234);
        look(32'h100, 1, 1, 32'h900, "R9");
        look(32'h3C0, 0, 0, 32'h3C4, "R9");
        // taken resolve: counter 00->01 (not taken), allocation replaces 0x100
        resolve(32'h3C0, 1, 32'h5000);
        look(32'h3C0, 1, 0, 32'h3C4, "R9");
        look(32'h100, 0, 1, 32'h104, "R7");

        // R10: lookup and resolve of the same PC in one cycle
        @(negedge clk);
        fetch_pc = 32'h3C0;
        rsv_valid = 1'b1; rsv_pc = 32'h3C0; rsv_taken = 1'b1; rsv_target = 32'h6000;
        push_exp(1, 0, 32'h3C4, "R10");
        @(posedge clk);
        #1 rsv_valid = 1'b0;
        look(32'h3C0, 1, 1, 32'h6000, "R10");

        // R2: another index, counter idx17 01->10
        resolve(32'h44, 1, 32'h2000);
        look(32'h44, 1, 1, 32'h2000, "R2");
        look(32'h3C0, 1, 1, 32'h6000, "R2");

        @(negedge clk);
        #3;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule